// File: doc/BRIEF.md
# Up/Down Timer with Master Trigger Output

This block is a general-purpose timer built around a counter that steps once per prescaler period and wraps at a programmable reload value. It counts either up or down. Each wrap raises a one-cycle update pulse. The reload value passes through a shadow stage. When buffering is enabled, a new reload value waits for the next update event. When buffering is disabled, the new value is used at once. The prescaler value is always shadowed. A software strobe forces an update event at any time. The event rate seen at the update output is the clock divided by (prescaler + 1) and then by (reload + 1).

A registered trigger output lets other timers follow this one. A 3-bit master-mode field selects its source: the forced-update strobe, the run bit, the update event, a compare pulse, or the level of the single compare channel's reference. Software programs the timer through a one-cycle write port, with an address and a data word.

Register addresses: 0 is control, 1 is prescaler, 2 is reload, 3 is compare, and 4 is the event strobe. The control word has these fields: run in bit 0, down in bit 1, reload buffering in bit 2, and master mode in bits 6:4. A write to address 4 with bit 0 set forces an update.

Top module: `tmr_master`

## Requirements
- R1: After synchronous reset, `count_o`, `update_o` and `trgo_o` are 0. Prescaler, reload, compare and control are all 0.
- R2: Counting up with prescaler P and reload N>0, the count advances once every P+1 clocks and goes from N to 0. On that wrap, `update_o` is high for one clock in the cycle the 0 appears. Update pulses are (P+1)(N+1) clocks apart.
- R3: Counting down (control bit 1 set), the count decreases by one per step and goes from 0 to the reload value. The wrap raises `update_o` the same way.
- R4: While control bit 0 (run) is clear, the count holds and no update pulse occurs, except when an update is forced.
- R5: With control bit 2 set, a write to address 2 is held in a buffer. The count keeps using the old reload value until the next update event.
- R6: With control bit 2 clear, a write to address 2 is used as the wrap limit from the next clock.
- R7: A write to address 4 with bit 0 set forces an update event. The forced update loads the buffered prescaler and reload values, restarts the prescaler, and sets the count to 0 (up) or to the buffered reload (down). It pulses `update_o` on the next clock. This works whether or not the counter is running.
- R8: A write to address 1 takes effect only at the next update event, whether natural or forced.
- R9: When the active reload value is 0, the count is held at 0 and no natural update events occur.
- R10: Master mode 0: `trgo_o` pulses for one clock, one clock after a forced update, and at no other time.
- R11: Master mode 1: `trgo_o` follows the run bit, one clock late.
- R12: Master mode 2: `trgo_o` pulses together with `update_o`, one clock after the update event.
- R13: Master mode 3: `trgo_o` pulses one clock after the counter steps onto the compare value. A forced update or a held count gives no pulse. Master mode 4: `trgo_o` is the level (count < compare), one clock late.
- R14: Master modes 5, 6 and 7 keep `trgo_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address (0 control, 1 prescaler, 2 reload, 3 compare, 4 event) |
| wr_data | input | DATA_W | Write data |
| count_o | output | CNT_W | Current counter value |
| update_o | output | 1 | One-cycle pulse after each update event |
| trgo_o | output | 1 | Registered master trigger output |

## Verification
A wrong shadow register shows up within one counting period. The wrap happens at the wrong count, or the pulse spacing differs from (P+1)(N+1) clocks, and the cycle-accurate reference flags the first mismatched count. A wrong prescaler phase or direction appears at `count_o` on the very next step. A wrong trigger source shows up on `trgo_o` one clock after its source event. The bench compares count, update and trigger against its own model on every clock, so the first bad cycle is reported.

// File: rtl/tmr_master_pkg.sv
package tmr_master_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PSC    = 3'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP    = 3'd3;
  localparam logic [ADDR_W-1:0] A_EVENT  = 3'd4;

  localparam int C_RUN  = 0;
  localparam int C_DOWN = 1;
  localparam int C_BUF  = 2;
  localparam int C_MODE = 4;

  typedef enum logic [2:0] {
    MM_RESET   = 3'd0,
    MM_ENABLE  = 3'd1,
    MM_UPDATE  = 3'd2,
    MM_CMPPULS = 3'd3,
    MM_REF1    = 3'd4,
    MM_REF2    = 3'd5,
    MM_REF3    = 3'd6,
    MM_REF4    = 3'd7
  } mmode_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_master_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              upd_ev_i,
  output logic              run_o,
  output logic              down_o,
  output mmode_e            mode_o,
  output logic              ug_o,
  output logic [PSC_W-1:0]  psc_act_o,
  output logic [CNT_W-1:0]  arr_buf_o,
  output logic [CNT_W-1:0]  arr_act_o,
  output logic [CNT_W-1:0]  cmp_o
);
  logic             run_q, down_q, buf_q;
  mmode_e           mode_q;
  logic [PSC_W-1:0] psc_buf_q, psc_act_q;
  logic [CNT_W-1:0] arr_buf_q, arr_act_q, cmp_q;
  logic             wr_arr;

  assign wr_arr = wr_en && (wr_addr == A_RELOAD);
  assign ug_o   = wr_en && (wr_addr == A_EVENT) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      down_q    <= 1'b0;
      buf_q     <= 1'b0;
      mode_q    <= MM_RESET;
      psc_buf_q <= '0;
      arr_buf_q <= '0;
      cmp_q     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          run_q  <= wr_data[C_RUN];
          down_q <= wr_data[C_DOWN];
          buf_q  <= wr_data[C_BUF];
          mode_q <= mmode_e'(wr_data[C_MODE +: 3]);
        end
        A_PSC:    psc_buf_q <= wr_data[PSC_W-1:0];
        A_RELOAD: arr_buf_q <= wr_data[CNT_W-1:0];
        A_CMP:    cmp_q     <= wr_data[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  // Active (shadow) values: an update event copies the buffers; an
  // unbuffered reload write goes straight through and wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      psc_act_q <= '0;
      arr_act_q <= '0;
    end else begin
      if (upd_ev_i) begin
        psc_act_q <= psc_buf_q;
        arr_act_q <= arr_buf_q;
      end
      if (wr_arr && !buf_q) arr_act_q <= wr_data[CNT_W-1:0];
    end
  end

  assign run_o     = run_q;
  assign down_o    = down_q;
  assign mode_o    = mode_q;
  assign psc_act_o = psc_act_q;
  assign arr_buf_o = arr_buf_q;
  assign arr_act_o = arr_act_q;
  assign cmp_o     = cmp_q;

  // R5
  buffered_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_q && !upd_ev_i) |=> $stable(arr_act_q));

  // R8
  psc_shadow_chk: assert property (@(posedge clk) disable iff (rst)
    (!upd_ev_i) |=> $stable(psc_act_q));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             ug_i,
  input  logic [PSC_W-1:0] psc_act_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] pcnt_q;

  assign tick_o = run_i && (pcnt_q == psc_act_i);

  always_ff @(posedge clk) begin
    if (rst || ug_i)   pcnt_q <= '0;
    else if (tick_o)   pcnt_q <= '0;
    else if (run_i)    pcnt_q <= pcnt_q + 1'b1;
  end

  // R4
  stopped_prescaler_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !ug_i) |=> $stable(pcnt_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             ug_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] arr_buf_i,
  input  logic [CNT_W-1:0] arr_act_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_ev_o,
  output logic             cmp_ev_o,
  output logic             upd_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_q, moved;

  always_comb begin
    cnt_d    = cnt_q;
    upd_ev_o = 1'b0;
    moved    = 1'b0;
    if (ug_i) begin
      upd_ev_o = 1'b1;
      cnt_d    = down_i ? arr_buf_i : '0;
    end else if (tick_i) begin
      if (arr_act_i == '0) begin
        cnt_d = '0;
      end else begin
        moved = 1'b1;
        if (!down_i) begin
          if (cnt_q >= arr_act_i) begin
            cnt_d    = '0;
            upd_ev_o = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == '0) begin
            cnt_d    = arr_buf_i;
            upd_ev_o = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
    end
  end

  assign cmp_ev_o = moved && (cnt_d == cmp_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      upd_q <= upd_ev_o;
    end
  end

  assign cnt_o = cnt_q;
  assign upd_o = upd_q;

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !ug_i) |=> $stable(cnt_q));

  // R2
  up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !ug_i && !down_i && arr_act_i != '0 && cnt_q >= arr_act_i)
      |=> (cnt_q == '0 && upd_q));

  // R9
  held_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_act_i == '0 && cnt_q == '0 && !ug_i) |=> (cnt_q == '0 && !upd_q));
endmodule

// File: rtl/tmr_trgo_sel.sv
module tmr_trgo_sel
  import tmr_master_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  mmode_e           mode_i,
  input  logic             ug_i,
  input  logic             run_i,
  input  logic             upd_ev_i,
  input  logic             cmp_ev_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             trgo_o
);
  logic trgo_q, src;
  logic ref1;

  assign ref1 = (cnt_i < cmp_i);

  always_comb begin
    case (mode_i)
      MM_RESET:   src = ug_i;
      MM_ENABLE:  src = run_i;
      MM_UPDATE:  src = upd_ev_i;
      MM_CMPPULS: src = cmp_ev_i;
      MM_REF1:    src = ref1;
      default:    src = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) trgo_q <= 1'b0;
    else     trgo_q <= src;
  end

  assign trgo_o = trgo_q;

  // R14
  unused_ref_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i > MM_REF1) |=> !trgo_q);

  // R12
  update_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MM_UPDATE && upd_ev_i) |=> trgo_q);

  // R10
  reset_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MM_RESET && !ug_i) |=> !trgo_q);
endmodule

// File: rtl/tmr_master.sv
module tmr_master
  import tmr_master_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count_o,
  output logic              update_o,
  output logic              trgo_o
);
  logic             run, down, ug, tick, upd_ev, cmp_ev;
  mmode_e           mode;
  logic [PSC_W-1:0] psc_act;
  logic [CNT_W-1:0] arr_buf, arr_act, cmp_val, cnt;

  tmr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd_ev_i(upd_ev), .run_o(run), .down_o(down), .mode_o(mode), .ug_o(ug),
    .psc_act_o(psc_act), .arr_buf_o(arr_buf), .arr_act_o(arr_act), .cmp_o(cmp_val)
  );

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run_i(run), .ug_i(ug), .psc_act_i(psc_act), .tick_o(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .ug_i(ug), .down_i(down),
    .arr_buf_i(arr_buf), .arr_act_i(arr_act), .cmp_i(cmp_val),
    .cnt_o(cnt), .upd_ev_o(upd_ev), .cmp_ev_o(cmp_ev), .upd_o(update_o)
  );

  tmr_trgo_sel #(.CNT_W(CNT_W)) u_trgo (
    .clk(clk), .rst(rst), .mode_i(mode), .ug_i(ug), .run_i(run),
    .upd_ev_i(upd_ev), .cmp_ev_i(cmp_ev), .cnt_i(cnt), .cmp_i(cmp_val),
    .trgo_o(trgo_o)
  );

  assign count_o = cnt;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (count_o == '0 && !update_o && !trgo_o));
endmodule

// File: tb/tmr_master_test.sv
`timescale 1ns/1ps
module tmr_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count_o;
  logic        update_o, trgo_o;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt, m_pcnt, m_psc_buf, m_psc_act, m_arr_buf, m_arr_act, m_cmp;
  int m_run, m_down, m_buf, m_mode, m_upd, m_trgo;

  tmr_master uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_o(count_o), .update_o(update_o), .trgo_o(trgo_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced once per rising edge
  always @(posedge clk) begin
    int ocnt, orun, omode, ocmp, obuf, ev, cev, moved, ug;
    if (rst) begin
      m_cnt = 0; m_pcnt = 0; m_psc_buf = 0; m_psc_act = 0; m_arr_buf = 0;
      m_arr_act = 0; m_cmp = 0; m_run = 0; m_down = 0; m_buf = 0; m_mode = 0;
      m_upd = 0; m_trgo = 0;
    end else begin
      ocnt = m_cnt; orun = m_run; omode = m_mode; ocmp = m_cmp; obuf = m_buf;
      ug = (wr_en && wr_addr == 3'd4 && wr_data[0]) ? 1 : 0;
      ev = 0; cev = 0; moved = 0;
      if (ug) begin
        ev = 1; m_pcnt = 0;
        m_cnt = m_down ? m_arr_buf : 0;
      end else if (m_run) begin
        if (m_pcnt == m_psc_act) begin
          m_pcnt = 0;
          if (m_arr_act == 0) m_cnt = 0;
          else begin
            moved = 1;
            if (!m_down) begin
              if (m_cnt >= m_arr_act) begin m_cnt = 0; ev = 1; end
              else m_cnt++;
            end else begin
              if (m_cnt == 0) begin m_cnt = m_arr_buf; ev = 1; end
              else m_cnt--;
            end
          end
        end else m_pcnt++;
      end
      if (moved && m_cnt == ocmp) cev = 1;
      case (omode)
        0: m_trgo = ug;
        1: m_trgo = orun;
        2: m_trgo = ev;
        3: m_trgo = cev;
        4: m_trgo = (ocnt < ocmp) ? 1 : 0;
        default: m_trgo = 0;
      endcase
      m_upd = ev;
      if (ev) begin m_psc_act = m_psc_buf; m_arr_act = m_arr_buf; end
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin
            m_run = wr_data[0]; m_down = wr_data[1]; m_buf = wr_data[2];
            m_mode = int'(wr_data[6:4]);
          end
          3'd1: m_psc_buf = int'(wr_data);
          3'd2: begin
            m_arr_buf = int'(wr_data);
            if (!obuf) m_arr_act = int'(wr_data);
          end
          3'd3: m_cmp = int'(wr_data);
          default: ;
        endcase
      end
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "count", int'(count_o), m_cnt);
      chk(cur_req, "update", int'(update_o), m_upd);
      chk(cur_req, "trgo", int'(trgo_o), m_trgo);
    end
  end

  function automatic logic [15:0] ctl(int run, int down, int bufd, int mode);
    return 16'((run & 1) | ((down & 1) << 1) | ((bufd & 1) << 2) | ((mode & 7) << 4));
  endfunction

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(string req, int exp);
    int guard, n;
    guard = 0;
    @(negedge clk);
    while (update_o !== 1'b1 && guard < 400) begin @(negedge clk); guard++; end
    n = 0;
    @(negedge clk); n = 1;
    while (update_o !== 1'b1 && n < 400) begin @(negedge clk); n++; end
    chk(req, "update spacing", n, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int u;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "count after reset", int'(count_o), 0);
    chk("R1", "update after reset", int'(update_o), 0);
    chk("R1", "trgo after reset", int'(trgo_o), 0);
    idle(3);

    // R2 / R12: up counting, prescaler 2, reload 4, update-driven trigger
    cur_req = "R2";
    wr(3'd1, 16'd2); wr(3'd2, 16'd4); wr(3'd4, 16'd1);
    wr(3'd0, ctl(1, 0, 0, 2));
    measure("R2", 15);
    cur_req = "R12";
    idle(40);

    // R5: buffered reload waits for the next update
    cur_req = "R5";
    wr(3'd0, ctl(1, 0, 1, 2)); idle(4);
    wr(3'd2, 16'd9); idle(60);

    // R6: unbuffered reload takes effect immediately
    cur_req = "R6";
    wr(3'd0, ctl(1, 0, 0, 2)); idle(5);
    wr(3'd2, 16'd3); idle(40);

    // R8: prescaler write waits for an update
    cur_req = "R8";
    wr(3'd1, 16'd0); idle(40);
    measure("R8", 4);

    // R3: down counting, prescaler 0, reload 3
    cur_req = "R3";
    wr(3'd1, 16'd0); wr(3'd2, 16'd3); wr(3'd4, 16'd1);
    wr(3'd0, ctl(1, 1, 0, 2));
    measure("R3", 4);
    idle(20);

    // R4: stopped counter holds
    cur_req = "R4";
    wr(3'd0, ctl(0, 1, 0, 2));
    u = 0;
    repeat (20) begin @(negedge clk); if (update_o) u++; end
    chk("R4", "updates while stopped", u, 0);

    // R7 / R10: forced update while stopped, reset-mode trigger
    cur_req = "R7";
    wr(3'd0, ctl(0, 1, 0, 0));
    wr(3'd2, 16'd6); wr(3'd1, 16'd1);
    wr(3'd4, 16'd1);
    chk("R7", "count after forced update (down)", int'(count_o), 6);
    chk("R7", "update after forced update", int'(update_o), 1);
    chk("R10", "trgo pulse on forced update", int'(trgo_o), 1);
    @(negedge clk);
    chk("R10", "trgo one clock only", int'(trgo_o), 0);
    chk("R4", "count holds while stopped", int'(count_o), 6);
    cur_req = "R10";
    wr(3'd0, ctl(1, 0, 0, 0)); idle(30);
    wr(3'd4, 16'd1); idle(10);

    // R11: enable-mode trigger
    cur_req = "R11";
    wr(3'd0, ctl(1, 0, 0, 1));
    chk("R11", "trgo lags run", int'(trgo_o), 0);
    @(negedge clk);
    chk("R11", "trgo follows run", int'(trgo_o), 1);
    idle(10);
    wr(3'd0, ctl(0, 0, 0, 1)); idle(5);
    wr(3'd0, ctl(1, 0, 0, 1)); idle(5);

    // R13: compare pulse and compare reference level
    cur_req = "R13";
    wr(3'd1, 16'd0); wr(3'd2, 16'd5); wr(3'd3, 16'd2); wr(3'd4, 16'd1);
    wr(3'd0, ctl(1, 0, 0, 3)); idle(30);
    wr(3'd0, ctl(1, 1, 0, 3)); idle(30);
    wr(3'd0, ctl(1, 0, 0, 4)); idle(30);

    // R14: unused reference modes
    cur_req = "R14";
    for (int m = 5; m < 8; m++) begin
      wr(3'd0, ctl(1, 0, 0, m));
      u = 0;
      repeat (15) begin @(negedge clk); if (trgo_o) u++; end
      chk("R14", "trgo high count", u, 0);
    end

    // R9: reload of zero holds the count at zero
    cur_req = "R9";
    wr(3'd0, ctl(1, 0, 0, 2));
    wr(3'd2, 16'd0); idle(3);
    u = 0;
    repeat (60) begin @(negedge clk); if (update_o) u++; end
    chk("R9", "updates with zero reload", u, 0);
    chk("R9", "count with zero reload", int'(count_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule